// File: doc/BRIEF.md
# Auxiliary Domain Power-Off and Bus Isolation Controller

This block decides when an auxiliary power domain may be switched off and when its bus is cut off from the host CPU bus. It holds five request bits: a power-off request, a power-down request, a bus disconnect request, an I/O latch enable, and the acknowledge and status bits that go with them. Two agents reach these bits through one small register port, the host CPU and a local sequencer. An always-on force-on input overrides the isolation and power-off requests. A power-up pulse from the always-on side clears the sticky power-off request.

The always-on acknowledge path for the power-down request is modelled inside the block. It has a fixed capture latency, set by a parameter, and feeds a synchroniser chain. The block drives four outputs: a power-off command to the domain switch, a bus isolation enable, the I/O latch control, and a low-power indication. The low-power indication tells local logic to assume a limited current supply.

Top module: `domain_pwr_iso`

## Requirements
- R1: `powerOffCmd` is 1 only when the power-off request is 1, `forceOn` is 0 and the bus disconnected status is 1. It is a combinational function of these three.
- R2: A write of 1 to address 0 sets the power-off request. A write of 0 has no effect. Only a `powerUp` pulse clears it, at the next clock edge.
- R3: The disconnect acknowledge (address 4 bit 0) takes the value of the disconnect request (address 3 bit 0) one cycle after the request changes. The disconnected status (address 4 bit 1) equals `busIsolate`. It is set one cycle after the acknowledge when `forceOn` is 0.
- R4: While `forceOn` is 1, the disconnect request is ignored. `busIsolate` is 0 from the first clock edge that sees `forceOn` high, unless the power-down acknowledge is 1. `powerOffCmd` drops at once.
- R5: The power-down acknowledge (address 2 bit 0) follows the power-down request (address 1 bit 0) ACK_DELAY+2 cycles after the request changes, with ACK_DELAY defaulting to 4. While the acknowledge is 1, `busIsolate` is 1 from the next cycle.
- R6: `domLowPower` is 1 while the power-down request or the power-down acknowledge is 1. After the request is cleared, it stays 1 until the acknowledge returns to 0.
- R7: The I/O latch field (address 5 bit 0) drives `ioLatchOpen`: 0 means latches closed with pin state held, 1 means transparent. After reset, every field and output is 0.
- R8: A host read (`regAgent`=0) while `busIsolate` is 1 returns 0 with `regRdErr`=1. Sequencer reads (`regAgent`=1) always return the value with `regRdErr`=0.
- R9: Host writes are ignored while `busIsolate` is 1. Sequencer writes always take effect.
- R10: Address 6 bit 0 reads `forceOn`, and address 7 reads 0. Reads are combinational, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| forceOn | input | 1 | Always-on override keeping the domain connected and powered |
| powerUp | input | 1 | Pulse marking a domain power-up; clears the power-off request |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAgent | input | 1 | Access origin: 0 host CPU, 1 local sequencer |
| regAddr | input | 3 | Register address |
| regWrBit | input | 1 | Write data (bit 0 of the addressed field) |
| regRdData | output | 2 | Read data |
| regRdErr | output | 1 | Host read refused because the bus is isolated |
| powerOffCmd | output | 1 | Domain power-off command |
| busIsolate | output | 1 | Bus isolation enable |
| ioLatchOpen | output | 1 | I/O latch control, 1 transparent |
| domLowPower | output | 1 | Domain must assume power-down supply limits |

## Verification
A wrong isolation state shows up at the ports in one of two ways. It either asserts `powerOffCmd` while the bus is still connected, or it refuses host reads one cycle later. The bench therefore samples `busIsolate`, `powerOffCmd` and `regRdErr` on the exact cycles that R3 and R4 name. A lost sticky bit, or a wrong acknowledge count, shows at the latest ACK_DELAY+2 cycles after the request changes. The bench samples on both sides of that cycle.

// File: rtl/domain_pwr_iso_pkg.sv
package domain_pwr_iso_pkg;
  localparam logic [2:0] ADDR_OFF     = 3'd0;
  localparam logic [2:0] ADDR_PDREQ   = 3'd1;
  localparam logic [2:0] ADDR_PDACK   = 3'd2;
  localparam logic [2:0] ADDR_DISC    = 3'd3;
  localparam logic [2:0] ADDR_BUSSTAT = 3'd4;
  localparam logic [2:0] ADDR_LATCH   = 3'd5;
  localparam logic [2:0] ADDR_OVR     = 3'd6;
  localparam logic AGENT_HOST = 1'b0;

  typedef struct packed {
    logic setOff;
    logic wrPdReq;
    logic wrDisc;
    logic wrLatch;
    logic wrBit;
  } ctrlStrobe_t;

  typedef struct packed {
    logic offReq;
    logic pdReq;
    logic pdAck;
    logic discReq;
    logic discAck;
    logic busDisc;
    logic latchOpen;
    logic forceOn;
  } dpStatus_t;
endpackage

// File: rtl/domain_pwr_iso_ctrl.sv
module domain_pwr_iso_ctrl
  import domain_pwr_iso_pkg::*;
(
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic        regAgent,
  input  logic [2:0]  regAddr,
  input  logic        regWrBit,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic [1:0]  regRdData,
  output logic        regRdErr
);
  logic hostBlocked;
  logic wrOk;

  assign hostBlocked = (regAgent == AGENT_HOST) && status.busDisc;
  assign wrOk = regWrEn && !hostBlocked;

  always_comb begin
    strobe.setOff  = wrOk && (regAddr == ADDR_OFF) && regWrBit;
    strobe.wrPdReq = wrOk && (regAddr == ADDR_PDREQ);
    strobe.wrDisc  = wrOk && (regAddr == ADDR_DISC);
    strobe.wrLatch = wrOk && (regAddr == ADDR_LATCH);
    strobe.wrBit   = regWrBit;
  end

  assign regRdErr = regRdEn && hostBlocked;

  always_comb begin
    regRdData = 2'b00;
    if (regRdEn && !hostBlocked) begin
      case (regAddr)
        ADDR_OFF:     regRdData = {1'b0, status.offReq};
        ADDR_PDREQ:   regRdData = {1'b0, status.pdReq};
        ADDR_PDACK:   regRdData = {1'b0, status.pdAck};
        ADDR_DISC:    regRdData = {1'b0, status.discReq};
        ADDR_BUSSTAT: regRdData = {status.busDisc, status.discAck};
        ADDR_LATCH:   regRdData = {1'b0, status.latchOpen};
        ADDR_OVR:     regRdData = {1'b0, status.forceOn};
        default:      regRdData = 2'b00;
      endcase
    end
  end
endmodule

// File: rtl/domain_pwr_iso_dp.sv
module domain_pwr_iso_dp
  import domain_pwr_iso_pkg::*;
#(
  parameter int ACK_DELAY   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        forceOn,
  input  logic        powerUp,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        powerOffCmd,
  output logic        busIsolate,
  output logic        ioLatchOpen,
  output logic        domLowPower
);
  localparam int CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

  logic offReq, pdReq, discReq, discAck, busDisc, latchOpen;
  logic aonCap;
  logic [CNT_W-1:0] aonCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic pdAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReq    <= 1'b0;
      pdReq     <= 1'b0;
      discReq   <= 1'b0;
      latchOpen <= 1'b0;
    end else begin
      if (powerUp)             offReq <= 1'b0;
      else if (strobe.setOff)  offReq <= 1'b1;
      if (strobe.wrPdReq)      pdReq <= strobe.wrBit;
      if (strobe.wrDisc)       discReq <= strobe.wrBit;
      if (strobe.wrLatch)      latchOpen <= strobe.wrBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discAck <= 1'b0;
      busDisc <= 1'b0;
    end else begin
      discAck <= discReq;
      busDisc <= (discAck && !forceOn) || pdAck;
    end
  end

  // Always-on capture of the power-down request after a fixed latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aonCap <= 1'b0;
      aonCnt <= '0;
    end else if (pdReq == aonCap) begin
      aonCnt <= '0;
    end else if (aonCnt == CNT_LAST) begin
      aonCap <= pdReq;
      aonCnt <= '0;
    end else begin
      aonCnt <= aonCnt + 1'b1;
    end
  end

  genvar k;
  generate
    for (k = 0; k < SYNC_STAGES; k++) begin : gSync
      if (k == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= aonCap;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[k] <= 1'b0;
          else       syncQ[k] <= syncQ[k-1];
      end
    end
  endgenerate

  assign pdAck = syncQ[SYNC_STAGES-1];

  assign powerOffCmd = offReq && !forceOn && busDisc;
  assign busIsolate  = busDisc;
  assign ioLatchOpen = latchOpen;
  assign domLowPower = pdReq || pdAck;

  always_comb begin
    status.offReq    = offReq;
    status.pdReq     = pdReq;
    status.pdAck     = pdAck;
    status.discReq   = discReq;
    status.discAck   = discAck;
    status.busDisc   = busDisc;
    status.latchOpen = latchOpen;
    status.forceOn   = forceOn;
  end
endmodule

// File: rtl/domain_pwr_iso.sv
module domain_pwr_iso
  import domain_pwr_iso_pkg::*;
#(
  parameter int ACK_DELAY   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       forceOn,
  input  logic       powerUp,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic       regAgent,
  input  logic [2:0] regAddr,
  input  logic       regWrBit,
  output logic [1:0] regRdData,
  output logic       regRdErr,
  output logic       powerOffCmd,
  output logic       busIsolate,
  output logic       ioLatchOpen,
  output logic       domLowPower
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        offReqQ;
  logic        pdAckQ;

  domain_pwr_iso_ctrl uCtrl (
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAgent (regAgent),
    .regAddr  (regAddr),
    .regWrBit (regWrBit),
    .status   (status),
    .strobe   (strobe),
    .regRdData(regRdData),
    .regRdErr (regRdErr)
  );

  domain_pwr_iso_dp #(.ACK_DELAY(ACK_DELAY), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .forceOn    (forceOn),
    .powerUp    (powerUp),
    .strobe     (strobe),
    .status     (status),
    .powerOffCmd(powerOffCmd),
    .busIsolate (busIsolate),
    .ioLatchOpen(ioLatchOpen),
    .domLowPower(domLowPower)
  );

  assign offReqQ = status.offReq;
  assign pdAckQ  = status.pdAck;
endmodule

// File: rtl/domain_pwr_iso_chk.sv
module domain_pwr_iso_chk (
  input logic       clk,
  input logic       rstN,
  input logic       forceOn,
  input logic       powerUp,
  input logic       powerOffCmd,
  input logic       busIsolate,
  input logic       regRdErr,
  input logic [1:0] regRdData,
  input logic       offReqQ,
  input logic       pdAckQ
);
  AST_OFF_GATED: assert property (@(posedge clk) disable iff (!rstN)
    powerOffCmd |-> (!forceOn && busIsolate)); // R1

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (offReqQ && !powerUp) |=> offReqQ); // R2

  AST_FORCE_RECONNECT: assert property (@(posedge clk) disable iff (!rstN)
    (forceOn && !pdAckQ) |=> !busIsolate); // R4

  AST_PDACK_ISOLATES: assert property (@(posedge clk) disable iff (!rstN)
    pdAckQ |=> busIsolate); // R5

  AST_RDERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdErr |-> (regRdData == 2'b00)); // R8
endmodule

bind domain_pwr_iso domain_pwr_iso_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .forceOn    (forceOn),
  .powerUp    (powerUp),
  .powerOffCmd(powerOffCmd),
  .busIsolate (busIsolate),
  .regRdErr   (regRdErr),
  .regRdData  (regRdData),
  .offReqQ    (offReqQ),
  .pdAckQ     (pdAckQ)
);

// File: tb/domain_pwr_iso_test.sv
`timescale 1ns/1ps
module domain_pwr_iso_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic forceOn = 1'b0, powerUp = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, regAgent = 1'b0, regWrBit = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [1:0] regRdData;
  logic regRdErr, powerOffCmd, busIsolate, ioLatchOpen, domLowPower;
  int errors = 0;
  int checks = 0;
  logic [1:0] rd;
  logic rdErr;

  always #4 clk = ~clk;

  domain_pwr_iso uut (
    .clk(clk), .rstN(rstN), .forceOn(forceOn), .powerUp(powerUp),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAgent(regAgent),
    .regAddr(regAddr), .regWrBit(regWrBit), .regRdData(regRdData),
    .regRdErr(regRdErr), .powerOffCmd(powerOffCmd), .busIsolate(busIsolate),
    .ioLatchOpen(ioLatchOpen), .domLowPower(domLowPower)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic agent, input logic [2:0] addr, input logic bitv);
    regWrEn = 1'b1; regAgent = agent; regAddr = addr; regWrBit = bitv;
    @(negedge clk);
    regWrEn = 1'b0; regWrBit = 1'b0;
  endtask

  task automatic rdReg(input logic agent, input logic [2:0] addr);
    regRdEn = 1'b1; regAgent = agent; regAddr = addr;
    #1;
    rd = regRdData; rdErr = regRdErr;
    regRdEn = 1'b0;
  endtask

  task automatic testReset();
    check("R7 latch reset", {1'b0, ioLatchOpen}, 2'd0);
    check("R7 outputs reset", {busIsolate, powerOffCmd}, 2'd0);
    check("R7 lowpower reset", {1'b0, domLowPower}, 2'd0);
    for (int a = 0; a < 8; a++) begin
      rdReg(1'b1, 3'(a));
      check("R7 register reset", rd, 2'd0);
    end
  endtask

  task automatic testDisconnect();
    wr(1'b1, 3'd3, 1'b1);
    rdReg(1'b1, 3'd4);
    check("R3 ack not yet", rd, 2'b00);
    idle(1);
    rdReg(1'b1, 3'd4);
    check("R3 ack follows request", rd, 2'b01);
    check("R3 not yet isolated", {1'b0, busIsolate}, 2'd0);
    idle(1);
    rdReg(1'b1, 3'd4);
    check("R3 disconnected status", rd, 2'b11);
    check("R3 busIsolate", {1'b0, busIsolate}, 2'd1);
  endtask

  task automatic testHostBlocked();
    rdReg(1'b0, 3'd3);
    check("R8 host read error", {rdErr, 1'b0}, 2'b10);
    check("R8 host read zero", rd, 2'd0);
    rdReg(1'b1, 3'd3);
    check("R8 sequencer read ok", {rdErr, rd[0]}, 2'b01);
    wr(1'b0, 3'd5, 1'b1);
    check("R9 host write ignored output", {1'b0, ioLatchOpen}, 2'd0);
    rdReg(1'b1, 3'd5);
    check("R9 host write ignored reg", rd, 2'd0);
  endtask

  task automatic testPowerOff();
    wr(1'b1, 3'd0, 1'b1);
    check("R1 power-off issued", {1'b0, powerOffCmd}, 2'd1);
    wr(1'b1, 3'd0, 1'b0);
    rdReg(1'b1, 3'd0);
    check("R2 write 0 ignored", rd, 2'd1);
    check("R2 command held", {1'b0, powerOffCmd}, 2'd1);
    forceOn = 1'b1; #1;
    check("R4 power-off blocked at once", {1'b0, powerOffCmd}, 2'd0);
    rdReg(1'b1, 3'd6);
    check("R10 override readback", rd, 2'd1);
    idle(1);
    check("R4 bus reconnected", {1'b0, busIsolate}, 2'd0);
    rdReg(1'b0, 3'd0);
    check("R8 host read ok when connected", {rdErr, rd[0]}, 2'b01);
    forceOn = 1'b0;
    idle(1);
    check("R1 isolation back, power-off again", {busIsolate, powerOffCmd}, 2'b11);
    powerUp = 1'b1;
    idle(1);
    powerUp = 1'b0;
    rdReg(1'b1, 3'd0);
    check("R2 cleared by power-up", rd, 2'd0);
    check("R1 command off after power-up", {1'b0, powerOffCmd}, 2'd0);
  endtask

  task automatic testPowerDown();
    wr(1'b1, 3'd3, 1'b0);
    idle(2);
    check("R3 reconnect after clear", {1'b0, busIsolate}, 2'd0);
    wr(1'b1, 3'd1, 1'b1);
    check("R6 low power on request", {1'b0, domLowPower}, 2'd1);
    idle(5);
    rdReg(1'b1, 3'd2);
    check("R5 ack not before delay", rd, 2'd0);
    idle(1);
    rdReg(1'b1, 3'd2);
    check("R5 ack after delay", rd, 2'd1);
    idle(1);
    check("R5 ack isolates bus", {1'b0, busIsolate}, 2'd1);
    wr(1'b1, 3'd1, 1'b0);
    check("R6 still low power after clear", {1'b0, domLowPower}, 2'd1);
    idle(5);
    check("R6 held until ack drops", {1'b0, domLowPower}, 2'd1);
    idle(1);
    check("R6 released with ack", {1'b0, domLowPower}, 2'd0);
    rdReg(1'b1, 3'd2);
    check("R5 ack cleared", rd, 2'd0);
  endtask

  task automatic testLatch();
    idle(2);
    wr(1'b1, 3'd5, 1'b1);
    check("R7 latch transparent", {1'b0, ioLatchOpen}, 2'd1);
    wr(1'b0, 3'd5, 1'b0);
    check("R9 host write when connected", {1'b0, ioLatchOpen}, 2'd0);
    rdReg(1'b1, 3'd7);
    check("R10 unused address", rd, 2'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2);
    rstN = 1'b1;
    idle(1);
    testReset();
    testDisconnect();
    testHostBlocked();
    testPowerOff();
    testPowerDown();
    testLatch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule